// File: doc/BRIEF.md
# Frame Interrupt Generator with Acknowledge

This block issues one active-low interrupt request to the CPU for each video frame. It watches two signals from the video timing counters. One is a single-cycle horizontal reset strobe, which marks the same point in every scanline. The other is an active-low vertical sync enable, which stays low for eight whole scanlines. The request is raised at the first horizontal reset that comes while vertical sync enable is low. It then stays asserted until the CPU acknowledges it, which the CPU does by driving its M1 and IORQ strobes low together.

There are two stages of state. The first stage samples vertical sync enable only on horizontal reset strobes, which gives a delayed copy of vsync. The second stage holds the request. A falling edge of the delayed copy sets it, and an acknowledge clears it. Because the delayed copy falls only once per frame, an acknowledge given during the vsync window cannot cause a second request in that frame. All state runs on the single T-state clock, and edges are found by comparing with a registered copy.

Top module: `frame_irq_gen`

## Requirements
- R1: While reset is active, and directly after it is released, `irqN` is high (inactive). A reset given while a request is pending returns `irqN` to high.
- R2: When `hRst` is 1 and `vSyncEnN` is 0 at a clock edge, and the delayed vsync was high before that edge, `irqN` goes low one clock edge later.
- R3: `vSyncEnN` going low with no `hRst` strobe leaves `irqN` high. Vertical sync enable is looked at only on edges where `hRst` is 1.
- R4: While no acknowledge arrives, a raised request stays low through every later cycle, including further `hRst` strobes.
- R5: An acknowledge is a cycle in which `m1N` and `iorqN` are both 0. It takes `irqN` high at the next edge. A cycle in which only one of the two is 0 has no effect.
- R6: An acknowledge given while `vSyncEnN` is still low does not lead to a second request in that frame, whatever number of `hRst` strobes follow.
- R7: If an acknowledge falls in the same cycle as a new set event, the set wins and `irqN` stays low.
- R8: After `vSyncEnN` has been sampled high on some `hRst`, a later low sample on `hRst` raises a fresh request.
- R9: If `vSyncEnN` falls N cycles before an `hRst` strobe, `irqN` falls N+1 clock edges after the edge that first saw `vSyncEnN` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | T-state clock |
| rstN | input | 1 | Synchronous reset, active low |
| hRst | input | 1 | One-cycle horizontal reset strobe, active high |
| vSyncEnN | input | 1 | Vertical sync enable, active low, low for eight scanlines |
| m1N | input | 1 | CPU M1 strobe, active low |
| iorqN | input | 1 | CPU IORQ strobe, active low |
| irqN | output | 1 | Interrupt request to the CPU, active low |

## Verification
The bench gives an acknowledge in the middle of the vsync window and then keeps sending `hRst` strobes. A design that latched the level of vsync directly would raise the request again at each of those strobes. It also lines up an acknowledge with the cycle of a set event. A design that gave clear the priority would lose that frame's request. Acknowledges where only one of M1 or IORQ is low catch decoders built with OR instead of AND. Whole frames are run with a scaled line length to measure the latency from vsync falling to the request. A request that came one cycle early or late, or more than once per frame, would show up there.

// File: rtl/frame_irq_pkg.sv
package frame_irq_pkg;

  // Strobes from the control section to the request latch.
  typedef struct packed {
    logic setReq;   // delayed vsync has just fallen
    logic clrReq;   // CPU acknowledge cycle seen
  } irqCtl_t;

endpackage

// File: rtl/frame_irq_ctrl.sv
module frame_irq_ctrl
  import frame_irq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    hRst,
  input  logic    vSyncEnN,
  input  logic    m1N,
  input  logic    iorqN,
  output irqCtl_t ctl
);

  // First stage: vsync sampled only on horizontal reset strobes.
  logic dlyVs;
  // Registered copy of the first stage, for edge detection.
  logic dlyVsQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dlyVs  <= 1'b1;
      dlyVsQ <= 1'b1;
    end else begin
      if (hRst) dlyVs <= vSyncEnN;
      dlyVsQ <= dlyVs;
    end
  end

  always_comb begin
    ctl.setReq = dlyVsQ & ~dlyVs;
    ctl.clrReq = ~m1N & ~iorqN;
  end

  // R3
  dly_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !hRst |=> $stable(dlyVs));

  // R2
  set_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.setReq |-> ($past(hRst) && !$past(vSyncEnN)));

  // R6
  set_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.setReq |=> !ctl.setReq);

endmodule

// File: rtl/frame_irq_latch.sv
module frame_irq_latch
  import frame_irq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  irqCtl_t ctl,
  output logic    irqN
);

  // Second stage: the pending request.
  logic pend;

  always_ff @(posedge clk) begin
    if (!rstN)           pend <= 1'b0;
    else if (ctl.setReq) pend <= 1'b1;
    else if (ctl.clrReq) pend <= 1'b0;
  end

  assign irqN = ~pend;

  // R7
  set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.setReq |=> !irqN);

  // R5
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.clrReq && !ctl.setReq) |=> irqN);

  // R4
  hold_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!irqN && !ctl.clrReq) |=> !irqN);

  // R3
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqN && !ctl.setReq) |=> irqN);

endmodule

// File: rtl/frame_irq_gen.sv
module frame_irq_gen
  import frame_irq_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic hRst,
  input  logic vSyncEnN,
  input  logic m1N,
  input  logic iorqN,
  output logic irqN
);

  irqCtl_t ctl;

  frame_irq_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .hRst     (hRst),
    .vSyncEnN (vSyncEnN),
    .m1N      (m1N),
    .iorqN    (iorqN),
    .ctl      (ctl)
  );

  frame_irq_latch u_latch (
    .clk  (clk),
    .rstN (rstN),
    .ctl  (ctl),
    .irqN (irqN)
  );

  // R1
  reset_idle_chk: assert property (@(posedge clk) !rstN |=> irqN);

endmodule

// File: tb/sim_frame_irq_gen.sv
`timescale 1ns/1ps
module sim_frame_irq_gen;

  localparam int LINE  = 16;  // scaled scanline length
  localparam int OFFS  = 4;   // vsync falls this many cycles before hRst
  localparam int VLINE = 8;   // vsync lines
  localparam int FLINE = 12;  // lines per frame

  // {hRst, vSyncEnN, m1N, iorqN, expected irqN after the edge}
  localparam logic [4:0] VEC [0:16] = '{
    5'b11111, 5'b00111, 5'b00111, 5'b10111, 5'b00110, 5'b00110,
    5'b10110, 5'b00001, 5'b10111, 5'b00111, 5'b01111, 5'b11111,
    5'b01111, 5'b10111, 5'b00010, 5'b00100, 5'b00001
  };

  logic clk = 1'b0;
  logic rstN, hRst, vSyncEnN, m1N, iorqN, irqN;
  int   checks = 0, fails = 0;
  bit   done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  frame_irq_gen u0 (.clk(clk), .rstN(rstN), .hRst(hRst), .vSyncEnN(vSyncEnN),
                    .m1N(m1N), .iorqN(iorqN), .irqN(irqN));

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: irqN=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chkInt(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic string vecReq(input int i);
    case (i)
      0, 1, 2, 3: return "R3";
      4, 5:       return "R2";
      6:          return "R4";
      7, 16:      return "R5";
      8, 9:       return "R6";
      10, 11, 12, 13: return "R8";
      default:    return "R5";
    endcase
  endfunction

  task automatic doReset();
    rstN = 1'b0; hRst = 1'b0; vSyncEnN = 1'b1; m1N = 1'b1; iorqN = 1'b1;
    step(); step();
    rstN = 1'b1;
  endtask

  // One frame; ackAfter < 0 means no acknowledge.
  task automatic runFrame(input int ackAfter, output int falls, output int lat);
    int lowCnt = 0, vsStep = -1, irqStep = -1;
    logic prev = irqN;
    falls = 0;
    for (int p = 0; p < LINE * FLINE; p++) begin
      hRst     = ((p % LINE) == 0);
      vSyncEnN = !(p >= LINE - OFFS && p < LINE - OFFS + VLINE * LINE);
      if (!vSyncEnN && vsStep < 0) vsStep = p;
      m1N   = !(ackAfter >= 0 && lowCnt == ackAfter);
      iorqN = m1N;
      step();
      if (!irqN) lowCnt++;
      if (prev && !irqN) begin
        falls++;
        if (irqStep < 0) irqStep = p;
      end
      prev = irqN;
    end
    hRst = 1'b0; m1N = 1'b1; iorqN = 1'b1; vSyncEnN = 1'b1;
    lat = irqStep - vsStep;
  endtask

  initial begin
    int falls, lat;
    // R1: reset state
    rstN = 1'b0; hRst = 1'b0; vSyncEnN = 1'b0; m1N = 1'b1; iorqN = 1'b1;
    step();
    chk("R1", irqN, 1'b1);
    vSyncEnN = 1'b1;
    step();
    rstN = 1'b1;
    step();
    chk("R1", irqN, 1'b1);

    // Vector table
    for (int i = 0; i < 17; i++) begin
      {hRst, vSyncEnN, m1N, iorqN} = VEC[i][4:1];
      step();
      chk(vecReq(i), irqN, VEC[i][0]);
    end

    // R7: acknowledge in the set cycle
    doReset();
    hRst = 1'b1; vSyncEnN = 1'b0; step();
    hRst = 1'b0; m1N = 1'b0; iorqN = 1'b0; step();
    chk("R7", irqN, 1'b0);
    step();
    chk("R5", irqN, 1'b1);
    m1N = 1'b1; iorqN = 1'b1; vSyncEnN = 1'b1;

    // Whole frames
    doReset();
    runFrame(3, falls, lat);
    chkInt("R6", falls, 1);
    chkInt("R9", lat, OFFS + 1);
    chk("R6", irqN, 1'b1);
    runFrame(-1, falls, lat);
    chkInt("R4", falls, 1);
    chk("R4", irqN, 1'b0);
    m1N = 1'b0; iorqN = 1'b0; step();
    m1N = 1'b1; iorqN = 1'b1;
    chk("R5", irqN, 1'b1);
    runFrame(0, falls, lat);
    chkInt("R8", falls, 1);
    chkInt("R9", lat, OFFS + 1);

    // R1: reset while pending
    hRst = 1'b1; vSyncEnN = 1'b0; step();
    hRst = 1'b0; step();
    chk("R2", irqN, 1'b0);
    rstN = 1'b0; step();
    chk("R1", irqN, 1'b1);
    rstN = 1'b1; vSyncEnN = 1'b1; step();
    chk("R1", irqN, 1'b1);

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule